// File: doc/BRIEF.md
# Serial Peripheral Interface Controller with Parity

This block is the controller side of a four-wire serial peripheral link. It generates the serial clock and an active-low chip select, and moves one word out on the output data line while it captures one word from the input data line. A frame begins when the host hands a word over through a valid/ready transmit port. The frame holds 4 to 16 data bits. An optional parity bit follows the data bits, and it comes last whether the data go out most-significant bit first or least-significant bit first.

All settings are static inputs: clock idle level, capture phase, shift order, frame length, parity enable and parity sense, and the divider. When a frame ends, the received word goes into a one-entry holding register. That register carries a valid flag, a sticky parity-error flag and an overrun flag, and the host empties it with a single-cycle take strobe. The host reads `busy` to learn when the link is free again.

Top module: `spi_par_ctrl`

## Requirements
- R1: `cfg_len` holds the number of data bits minus one; valid values are 3 to 15. A frame has N = `cfg_len`+1+`cfg_par_en` bit periods and exactly 2N serial clock edges while chip select is low.
- R2: `cfg_lsb_first`=0 sends and receives data bit `cfg_len` first, down to bit 0. `cfg_lsb_first`=1 sends and receives bit 0 first, up to bit `cfg_len`.
- R3: With `cfg_par_en`=1, one parity bit follows the last data bit in both bit orders. `cfg_par_odd`=0 makes the count of ones over data plus parity even, and `cfg_par_odd`=1 makes it odd.
- R4: A received parity bit that does not match sets `rx_perr` together with `rx_valid`. The flag stays set, even when a later correct word lands on top of it, until the word is taken with `rx_ready`.
- R5: Transmit bits above `cfg_len` are ignored: they are never sent and never enter the parity. `rx_data` bits above `cfg_len` read zero.
- R6: `rx_valid` rises only in the cycle in which chip select returns high, after all N bits have been shifted in.
- R7: Whenever chip select is high, `sclk` rests at `cfg_cpol`.
- R8: `cfg_cpha`=0 captures data on the first (leading) edge of each bit period and launches data on the trailing edge. `cfg_cpha`=1 launches on the leading edge and captures on the trailing edge. In both modes the first data bit is already on `mosi` when chip select falls.
- R9: `cs_n` stays low, and `busy` stays high, from the cycle after the start is accepted until one half bit-period after the last capture edge. That makes (2N+`cfg_cpha`)×(`cfg_div`+1) cycles. `sclk` is at its idle level when `cs_n` rises.
- R10: Each half period of `sclk` lasts `cfg_div`+1 system clock cycles.
- R11: If a word is delivered while `rx_valid` is set and no take happens in that cycle, `rx_ovr` is set and the new word replaces the old one. A take clears `rx_valid`, `rx_ovr` and `rx_perr`.
- R12: `tx_ready` is low while a frame is in progress. A `tx_valid` asserted during a frame neither alters that frame nor starts another one.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_cpol | input | 1 | Serial clock idle level |
| cfg_cpha | input | 1 | 0: capture on leading edge, 1: capture on trailing edge |
| cfg_lsb_first | input | 1 | Shift order, 1 = least-significant bit first |
| cfg_len | input | LW (4) | Data bits per frame minus one (3 to 15) |
| cfg_par_en | input | 1 | Append and check a parity bit |
| cfg_par_odd | input | 1 | 0: even parity, 1: odd parity |
| cfg_div | input | DIVW (8) | Half-period length minus one, in system clocks |
| tx_valid | input | 1 | Transmit word offered |
| tx_data | input | DW (16) | Transmit word, right aligned |
| tx_ready | output | 1 | Controller idle, accepts a word |
| rx_ready | input | 1 | Host takes the held receive word |
| rx_valid | output | 1 | Receive holding register full |
| rx_data | output | DW (16) | Received word, right aligned, zero above the length |
| rx_perr | output | 1 | Sticky parity error for the held word |
| rx_ovr | output | 1 | An unread word was overwritten |
| busy | output | 1 | Frame in progress |
| sclk | output | 1 | Serial clock |
| cs_n | output | 1 | Chip select, active low |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |

## Verification
The assertions check the timing rules on every cycle: the count of clock edges per frame, the half-period spacing, the idle level of the clock, the clock level when chip select rises, and that receive delivery and overrun coincide with chip select release. The bit order on the wire, the parity value and sense, the masking of bits above the length, and the captured word under both phases do not show in any single-cycle relation. Only the bench's sweep over every mode, length and divider can show them, with a peripheral model that launches and captures on the opposite edges. The sticky parity flag under overrun, and the take that clears it, are shown by a directed scenario.

// File: rtl/spi_par_pkg.sv
package spi_par_pkg;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } spi_st_e;

endpackage

// File: rtl/spi_par_tick.sv
// Half-period strobe: pulses once every div+1 cycles while enabled.
module spi_par_tick #(
    parameter int DIVW = 8
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            en,
    input  logic [DIVW-1:0] div,
    output logic            tick
);

    logic [DIVW-1:0] cnt_d, cnt_q;

    always_comb begin
        tick  = en && (cnt_q == div);
        cnt_d = cnt_q;
        if (!en || tick) begin
            cnt_d = '0;
        end else begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

endmodule

// File: rtl/spi_par_order.sv
// Masks a word to len+1 bits, optionally mirrors it within that width,
// and reports the XOR of the kept bits.
module spi_par_order #(
    parameter int DW = 16,
    localparam int LW = $clog2(DW)
) (
    input  logic [DW-1:0] din,
    input  logic [LW-1:0] len,
    input  logic          rev,
    output logic [DW-1:0] dout,
    output logic          par
);

    always_comb begin
        dout = '0;
        for (int i = 0; i < DW; i++) begin
            if (i <= int'(len)) begin
                if (rev) begin
                    dout[i] = din[int'(len) - i];
                end else begin
                    dout[i] = din[i];
                end
            end
        end
        par = ^dout;
    end

endmodule

// File: rtl/spi_par_rxhold.sv
// One-entry receive holding register with sticky error and overrun flags.
module spi_par_rxhold #(
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          push_err,
    input  logic          pop,
    output logic          valid,
    output logic [DW-1:0] data,
    output logic          perr,
    output logic          ovr
);

    typedef struct packed {
        logic          valid;
        logic [DW-1:0] data;
        logic          perr;
        logic          ovr;
    } hold_t;

    hold_t h_d, h_q;
    logic  take;

    always_comb begin
        h_d  = h_q;
        take = pop && h_q.valid;
        if (take) begin
            h_d.valid = 1'b0;
            h_d.perr  = 1'b0;
            h_d.ovr   = 1'b0;
        end
        if (push) begin
            h_d.valid = 1'b1;
            h_d.data  = push_data;
            h_d.perr  = (take ? 1'b0 : h_q.perr) | push_err;
            h_d.ovr   = take ? 1'b0 : (h_q.ovr | h_q.valid);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign valid = h_q.valid;
    assign data  = h_q.data;
    assign perr  = h_q.perr;
    assign ovr   = h_q.ovr;

endmodule

// File: rtl/spi_par_ctrl.sv
module spi_par_ctrl #(
    parameter int DW   = 16,
    parameter int DIVW = 8,
    localparam int LW  = $clog2(DW),
    localparam int FW  = DW + 1,
    localparam int CW  = $clog2(2 * FW + 2)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_cpol,
    input  logic            cfg_cpha,
    input  logic            cfg_lsb_first,
    input  logic [LW-1:0]   cfg_len,
    input  logic            cfg_par_en,
    input  logic            cfg_par_odd,
    input  logic [DIVW-1:0] cfg_div,
    input  logic            tx_valid,
    input  logic [DW-1:0]   tx_data,
    output logic            tx_ready,
    input  logic            rx_ready,
    output logic            rx_valid,
    output logic [DW-1:0]   rx_data,
    output logic            rx_perr,
    output logic            rx_ovr,
    output logic            busy,
    output logic            sclk,
    output logic            cs_n,
    output logic            mosi,
    input  logic            miso
);

    import spi_par_pkg::*;

    typedef struct packed {
        spi_st_e        st;
        logic           cs_n;
        logic           busy;
        logic           sclk;
        logic [CW-1:0]  tcnt;
        logic [FW-1:0]  tx_sr;
        logic [FW-1:0]  rx_sr;
    } ctl_t;

    ctl_t s_d, s_q;

    logic          tick;
    logic          push;
    logic [DW-1:0] tx_vec;
    logic          tx_par;
    logic [DW-1:0] rx_raw;
    logic [DW-1:0] rx_word;
    logic          rx_par;
    logic          rx_err;
    logic [FW-1:0] load_vec;
    logic [CW-1:0] two_n;
    logic [CW-1:0] end_t;
    logic [CW-1:0] t_nx;
    logic          cap;

    spi_par_tick #(.DIVW(DIVW)) u_tick (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (s_q.st == ST_RUN),
        .div   (cfg_div),
        .tick  (tick)
    );

    spi_par_order #(.DW(DW)) u_tx_order (
        .din  (tx_data),
        .len  (cfg_len),
        .rev  (cfg_lsb_first),
        .dout (tx_vec),
        .par  (tx_par)
    );

    spi_par_order #(.DW(DW)) u_rx_order (
        .din  (rx_raw),
        .len  (cfg_len),
        .rev  (cfg_lsb_first),
        .dout (rx_word),
        .par  (rx_par)
    );

    spi_par_rxhold #(.DW(DW)) u_hold (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_word),
        .push_err  (rx_err),
        .pop       (rx_ready),
        .valid     (rx_valid),
        .data      (rx_data),
        .perr      (rx_perr),
        .ovr       (rx_ovr)
    );

    // Frame geometry and the serialised start image (first bit at the top).
    always_comb begin
        two_n    = CW'(2 * (int'(cfg_len) + 1 + int'(cfg_par_en)));
        end_t    = two_n + CW'(cfg_cpha);
        load_vec = '0;
        for (int j = 0; j < FW; j++) begin
            if (j <= int'(cfg_len)) begin
                load_vec[FW-1-j] = tx_vec[int'(cfg_len) - j];
            end else if (j == int'(cfg_len) + 1) begin
                load_vec[FW-1-j] = cfg_par_en & (tx_par ^ cfg_par_odd);
            end
        end
    end

    // Received image: last bit at position 0; strip parity when present.
    always_comb begin
        rx_raw = cfg_par_en ? s_q.rx_sr[DW:1] : s_q.rx_sr[DW-1:0];
        rx_err = cfg_par_en & (rx_par ^ s_q.rx_sr[0] ^ cfg_par_odd);
    end

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        t_nx = s_q.tcnt + 1'b1;
        cap  = t_nx[0] ^ cfg_cpha;
        unique case (s_q.st)
            ST_IDLE: begin
                s_d.sclk = cfg_cpol;
                if (tx_valid) begin
                    s_d.st    = ST_RUN;
                    s_d.cs_n  = 1'b0;
                    s_d.busy  = 1'b1;
                    s_d.tcnt  = '0;
                    s_d.tx_sr = load_vec;
                    s_d.rx_sr = '0;
                end
            end
            ST_RUN: begin
                if (tick) begin
                    s_d.tcnt = t_nx;
                    if (t_nx <= two_n) begin
                        s_d.sclk = ~s_q.sclk;
                        if (cap) begin
                            s_d.rx_sr = {s_q.rx_sr[FW-2:0], miso};
                        end else if (!(cfg_cpha && t_nx == CW'(1)) &&
                                     !(!cfg_cpha && t_nx == two_n)) begin
                            s_d.tx_sr = {s_q.tx_sr[FW-2:0], 1'b0};
                        end
                    end
                    if (t_nx == end_t) begin
                        s_d.st   = ST_IDLE;
                        s_d.cs_n = 1'b1;
                        s_d.busy = 1'b0;
                        push     = 1'b1;
                    end
                end
            end
            default: s_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q      <= '0;
            s_q.st   <= ST_IDLE;
            s_q.cs_n <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign tx_ready = (s_q.st == ST_IDLE);
    assign busy     = s_q.busy;
    assign sclk     = s_q.sclk;
    assign cs_n     = s_q.cs_n;
    assign mosi     = s_q.tx_sr[FW-1];

endmodule

// File: rtl/spi_par_chk.sv
module spi_par_chk #(
    parameter int DW   = 16,
    parameter int DIVW = 8,
    localparam int LW  = $clog2(DW),
    localparam int CW  = $clog2(2 * (DW + 1) + 2)
) (
    input logic            clk,
    input logic            rst_n,
    input logic            cfg_cpol,
    input logic [LW-1:0]   cfg_len,
    input logic            cfg_par_en,
    input logic [DIVW-1:0] cfg_div,
    input logic            tx_valid,
    input logic            tx_ready,
    input logic            busy,
    input logic            cs_n,
    input logic            sclk,
    input logic            rx_valid,
    input logic            rx_ovr
);

    logic            sclk_prev_q;
    logic            cs_prev_q;
    logic            seen_q;
    logic [1:0]      live_q;
    logic [DIVW:0]   gap_q;
    logic [CW-1:0]   ecnt_q;
    logic            chg;
    logic [CW-1:0]   want_edges;

    assign chg        = (sclk != sclk_prev_q);
    assign want_edges = CW'(2 * (int'(cfg_len) + 1 + int'(cfg_par_en)));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            cs_prev_q   <= 1'b1;
            seen_q      <= 1'b0;
            live_q      <= '0;
            gap_q       <= '0;
            ecnt_q      <= '0;
        end else begin
            sclk_prev_q <= sclk;
            cs_prev_q   <= cs_n;
            if (live_q != 2'd3) live_q <= live_q + 1'b1;
            if (chg) begin
                gap_q <= '0;
            end else if (gap_q != {(DIVW+1){1'b1}}) begin
                gap_q <= gap_q + 1'b1;
            end
            if (cs_n) begin
                seen_q <= 1'b0;
            end else if (chg) begin
                seen_q <= 1'b1;
            end
            if (cs_n && cs_prev_q) begin
                ecnt_q <= '0;
            end else begin
                ecnt_q <= ecnt_q + CW'(chg);
            end
        end
    end

    // R1
    edge_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_prev_q) |-> (ecnt_q + CW'(chg) == want_edges));

    // R10
    half_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (chg && seen_q && !cs_n) |-> (gap_q == {1'b0, cfg_div}));

    // R7
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q == 2'd3 && cs_n && cs_prev_q && $stable(cfg_cpol)) |-> (sclk == cfg_cpol));

    // R9
    release_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cs_n && !cs_prev_q) |-> (sclk == cfg_cpol));

    // R9
    busy_select_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy == !cs_n);

    // R6
    deliver_at_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_valid) |-> (cs_n && !cs_prev_q));

    // R11
    overrun_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_ovr) |-> (cs_n && !cs_prev_q && $past(rx_valid)));

    // R12
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(tx_valid && tx_ready));

endmodule

bind spi_par_ctrl spi_par_chk #(.DW(DW), .DIVW(DIVW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_cpol   (cfg_cpol),
    .cfg_len    (cfg_len),
    .cfg_par_en (cfg_par_en),
    .cfg_div    (cfg_div),
    .tx_valid   (tx_valid),
    .tx_ready   (tx_ready),
    .busy       (busy),
    .cs_n       (cs_n),
    .sclk       (sclk),
    .rx_valid   (rx_valid),
    .rx_ovr     (rx_ovr)
);

// File: tb/tb_spi_par_ctrl.sv
`timescale 1ns/1ps
module tb_spi_par_ctrl;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_cpol = 1'b0, cfg_cpha = 1'b0, cfg_lsb_first = 1'b0;
    logic [3:0]  cfg_len = 4'd7;
    logic        cfg_par_en = 1'b0, cfg_par_odd = 1'b0;
    logic [7:0]  cfg_div = 8'd0;
    logic        tx_valid = 1'b0;
    logic [15:0] tx_data = '0;
    logic        tx_ready;
    logic        rx_ready = 1'b0;
    logic        rx_valid;
    logic [15:0] rx_data;
    logic        rx_perr, rx_ovr, busy, sclk, cs_n, mosi;
    logic        miso = 1'b0;

    int compared = 0;
    int mismatched = 0;
    int wd = 0;

    always #2.5 clk = ~clk;

    spi_par_ctrl dut (
        .clk(clk), .rst_n(rst_n), .cfg_cpol(cfg_cpol), .cfg_cpha(cfg_cpha),
        .cfg_lsb_first(cfg_lsb_first), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_div(cfg_div), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_ready(tx_ready), .rx_ready(rx_ready),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_perr(rx_perr), .rx_ovr(rx_ovr),
        .busy(busy), .sclk(sclk), .cs_n(cs_n), .mosi(mosi), .miso(miso)
    );

    // Peripheral model: launches on the non-capture edges, records mosi on capture edges.
    logic [16:0] m_sfr = '0;
    logic [16:0] got = '0;
    int          m_pi = 0, m_ci = 0, m_k = 0;
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;

    always @(negedge clk) begin
        if (prev_cs && !cs_n) begin
            m_pi = 0; m_ci = 0; m_k = 0; got = '0;
            miso = m_sfr[0];
        end else if (!cs_n && sclk != prev_sclk) begin
            m_k++;
            if (cfg_cpha ? (sclk == cfg_cpol) : (sclk != cfg_cpol)) begin
                if (m_ci < 17) got[m_ci] = mosi;
                m_ci++;
            end else if (!(cfg_cpha && m_k == 1)) begin
                m_pi++;
                miso = (m_pi < 17) ? m_sfr[m_pi] : 1'b0;
            end
        end
        prev_cs = cs_n;
        prev_sclk = sclk;
    end

    task automatic summary();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    endtask

    always @(posedge clk) begin
        wd++;
        if (wd > 150000) begin
            mismatched++;
            $display("FAIL watchdog: run did not finish (actual %0d cycles, expected < 150000)", wd);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    // Frame image: bit j is the j-th bit on the wire.
    function automatic logic [16:0] frame_bits(input logic [15:0] d, input bit flip);
        logic [16:0] f = '0;
        logic [15:0] m = d & 16'((32'h1 << (cfg_len + 1)) - 1);
        for (int j = 0; j <= int'(cfg_len); j++)
            f[j] = cfg_lsb_first ? m[j] : m[int'(cfg_len) - j];
        if (cfg_par_en) f[cfg_len + 1] = (^m) ^ cfg_par_odd ^ flip;
        return f;
    endfunction

    task automatic run_frame(input logic [15:0] td, input logic [15:0] pd,
                             input bit inj, input bit poke, input bit pop);
        int n = int'(cfg_len) + 1 + int'(cfg_par_en);
        logic [16:0] nmask = 17'((33'h1 << n) - 1);
        logic [16:0] exp_tx = frame_bits(td, 1'b0);
        logic [15:0] dmask = 16'((32'h1 << (cfg_len + 1)) - 1);
        int bcnt = 0;
        int want_b = (2 * n + int'(cfg_cpha)) * (int'(cfg_div) + 1);
        m_sfr = frame_bits(pd, inj);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = td;
        @(negedge clk);
        tx_valid = 1'b0; tx_data = 16'hFFFF;
        while (cs_n == 1'b0) begin
            bcnt++;
            if (poke && bcnt == 2) begin
                chk(tx_ready == 1'b0, "R12 ready low in frame", int'(tx_ready), 0);
                tx_valid = 1'b1; tx_data = ~td;
            end
            if (poke && bcnt == 4) tx_valid = 1'b0;
            @(negedge clk);
        end
        chk(bcnt == want_b, "R9/R10 busy length", bcnt, want_b);
        chk(m_ci == n, "R1/R8 capture count", m_ci, n);
        chk((got & nmask) == exp_tx, "R2/R3/R5 mosi bits", int'(got & nmask), int'(exp_tx));
        chk(sclk == cfg_cpol, "R7/R9 idle level at release", int'(sclk), int'(cfg_cpol));
        chk(rx_valid == 1'b1, "R6 rx_valid at release", int'(rx_valid), 1);
        chk(rx_data == (pd & dmask), "R2/R5/R8 rx_data", int'(rx_data), int'(pd & dmask));
        chk(rx_perr == inj, "R4 parity flag", int'(rx_perr), int'(inj));
        if (poke) begin
            @(negedge clk);
            chk(cs_n == 1'b1 && busy == 1'b0, "R12 no frame from ignored write",
                int'({cs_n, busy}), 2);
        end
        if (pop) begin
            rx_ready = 1'b1;
            @(negedge clk);
            rx_ready = 1'b0;
            chk(rx_valid == 1'b0 && rx_perr == 1'b0 && rx_ovr == 1'b0, "R11 take clears",
                int'({rx_valid, rx_perr, rx_ovr}), 0);
        end
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(cs_n == 1'b1 && busy == 1'b0, "R9 reset idle", int'({cs_n, busy}), 2);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_ready == 1'b1 && rx_valid == 1'b0, "R12 reset ready", int'({tx_ready, rx_valid}), 2);
        chk(sclk == 1'b0, "R7 idle low", int'(sclk), 0);
        cfg_cpol = 1'b1;
        repeat (2) @(negedge clk);
        chk(sclk == 1'b1, "R7 idle high", int'(sclk), 1);

        for (int idx = 0; idx < 416; idx++) begin
            cfg_cpol      = idx[0];
            cfg_cpha      = idx[1];
            cfg_lsb_first = idx[2];
            cfg_par_en    = idx[3];
            cfg_par_odd   = idx[4];
            cfg_len       = 4'(3 + (idx >> 5));
            cfg_div       = 8'(idx % 3);
            run_frame(16'(32'hA5C3 ^ (idx * 32'h3B1D)), 16'(32'h5E27 + idx * 32'h1F09),
                      idx[3] && ((idx / 2) % 3 == 0), (idx % 4) == 0, 1'b1);
        end

        // R11 and R4: overrun keeps the newest word and the sticky error.
        cfg_cpol = 1'b0; cfg_cpha = 1'b0; cfg_lsb_first = 1'b0; cfg_len = 4'd7;
        cfg_par_en = 1'b1; cfg_par_odd = 1'b0; cfg_div = 8'd1;
        run_frame(16'h0011, 16'h003C, 1'b1, 1'b0, 1'b0);
        chk(rx_ovr == 1'b0, "R11 no overrun on first word", int'(rx_ovr), 0);
        m_sfr = frame_bits(16'h0081, 1'b0);
        @(negedge clk);
        tx_valid = 1'b1; tx_data = 16'h0022;
        @(negedge clk);
        tx_valid = 1'b0;
        while (cs_n == 1'b0) @(negedge clk);
        chk(rx_ovr == 1'b1, "R11 overrun set", int'(rx_ovr), 1);
        chk(rx_data == 16'h0081, "R11 newest word kept", int'(rx_data), 32'h81);
        chk(rx_perr == 1'b1, "R4 sticky parity error", int'(rx_perr), 1);
        rx_ready = 1'b1;
        @(negedge clk);
        rx_ready = 1'b0;
        chk(rx_valid == 1'b0 && rx_ovr == 1'b0 && rx_perr == 1'b0, "R11 R4 take clears",
            int'({rx_valid, rx_ovr, rx_perr}), 0);

        summary();
        $finish;
    end

endmodule